// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of prepared transfers with no processor help. Software fills a transmit word queue and a command byte queue, sets a first and a last queue index, and sets an enable bit. The controller then sends each entry in turn, full duplex. Each received word is stored in a receive queue at the index of the entry that produced it. When the last entry has been sent, the enable bit clears itself and a finished flag is raised for software to poll.

Each command byte controls its own transfer. It sets the word length, the gap after the word, the delay between chip select and the first clock, the pattern on the four chip-select outputs, and whether that pattern is held into the next entry. The clock idles low. MOSI changes on falling SCK edges. MISO is captured on rising edges. Data is sent MSB first.

Top module: `qspi_master`

## Requirements
- R1: After reset, PCS outputs are 4'hF, SCK and MOSI are low, the control register reads 0, and every receive entry reads 0.
- R2: Register map by address: 0x00–0x0F transmit words, 0x10–0x1F command bytes (low 8 bits), 0x20–0x2F receive words (read-only), 0x30 pointers (bits 3:0 first index, bits 7:4 last index), 0x31 length (bits 4:0), 0x32 post-transfer delay, 0x33 lead delay, 0x34 SCK half-period divider, 0x35 idle PCS levels (bits 3:0, driven on PCS while the sequencer is idle), 0x36 control (bit 0 enable, bit 1 finished). All registers read back what was written.
- R3: Transfers are full duplex and MSB first. A word of N bits sends the low N bits of the transmit entry. The N bits sampled from MISO on rising SCK edges are stored right-justified, with zero upper bits, in the receive entry of the same index.
- R4: Command bit 6 clear gives an 8-bit transfer. Bit 6 set takes the length from register 0x31 when it lies in 8..16, and gives 16 bits for any other value.
- R5: SCK high and low phases each last the divider value in clock cycles, with 0 treated as 1.
- R6: Command bit 4 clear puts one SCK half period between the chip-select change and the first rising SCK edge. Bit 4 set uses register 0x33 cycles instead, with 0 treated as 1.
- R7: Command bit 5 clear inserts 17 clock cycles from the last falling SCK edge of an entry to the select of the next entry. Bit 5 set uses register 0x32 cycles, with 0 treated as 1.
- R8: During a transfer PCS carries command bits 3:0. Command bit 7 clear returns PCS to the idle levels during the post-transfer delay. Bit 7 set keeps the entry's pattern until the next entry loads. When the sequence completes, PCS returns to the idle levels.
- R9: Entries run from the first index to the last index inclusive, stepping modulo 16, so a last index below the first index wraps through 15 to 0. Receive entries outside the range are untouched.
- R10: Writing control with bit 0 set while idle starts a sequence. On completion bit 0 clears and bit 1 sets. Writing control with bit 1 clear clears the finished flag.
- R11: Writes to the transmit and command queues are ignored while bit 0 of control is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| pcs_o | output | 4 | Chip-select outputs |

## Verification
A wrong bit counter or length decode shows on SCK within one transfer: the number of rising edges per word differs from the length the command byte asks for. A wrong delay or divider counter shows as a miscounted phase, visible in the cycles between a chip-select change and the first clock, or between the last falling edge and the next select. A wrong index or a shift register that is not cleared shows only after completion, as receive words that are misplaced or do not equal the inverse of the transmit word under a MISO-equals-not-MOSI loopback. Queue lock faults show when the transmit queue is read back after the run.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int unsigned Q_DEPTH     = 16;
  localparam int unsigned Q_DATA_W    = 16;
  localparam int unsigned Q_CMD_W     = 8;
  localparam int unsigned Q_LEN_W     = 5;
  localparam int unsigned Q_DLY_W     = 8;
  localparam int unsigned Q_PCS_W     = 4;
  localparam int unsigned Q_ADDR_W    = 7;
  localparam int unsigned FIXED_TRAIL = 17;
  localparam int unsigned MIN_LEN     = 8;

  typedef struct packed {
    logic             hold;   // keep pattern after word
    logic             use_len;
    logic             use_post;
    logic             use_lead;
    logic [3:0]       pcs;
  } qcmd_t;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_TRAIL} seq_state_e;

  localparam logic [2:0] AREA_TX  = 3'd0;
  localparam logic [2:0] AREA_CMD = 3'd1;
  localparam logic [2:0] AREA_RX  = 3'd2;
  localparam logic [2:0] AREA_REG = 3'd3;

  localparam logic [3:0] REG_PTR  = 4'd0;
  localparam logic [3:0] REG_LEN  = 4'd1;
  localparam logic [3:0] REG_POST = 4'd2;
  localparam logic [3:0] REG_LEAD = 4'd3;
  localparam logic [3:0] REG_DIV  = 4'd4;
  localparam logic [3:0] REG_IDLE = 4'd5;
  localparam logic [3:0] REG_CTRL = 4'd6;
endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          lock_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && !lock_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R11: locked writes leave the addressed entry unchanged
  a_r11_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_i) |=> mem_q[$past(waddr_i)] == $past(mem_q[waddr_i]));
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
  parameter int unsigned W  = 16,
  parameter int unsigned LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic [W-1:0]  word_i,
  input  logic          shift_i,
  input  logic          sample_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic [W-1:0]  rx_o
);
  logic [W-1:0]  tx_q, rx_q;
  logic [LW-1:0] shamt;

  assign shamt = LW'(W) - len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= word_i << shamt;  // left-align low bits
      else if (shift_i) tx_q <= {tx_q[W-2:0], 1'b0};
      if (load_i)        rx_q <= '0;
      else if (sample_i) rx_q <= {rx_q[W-2:0], miso_i};
    end
  end

  assign mosi_o = tx_q[W-1];
  assign rx_o   = rx_q;

  // R3: first bit on the line is the top bit of the selected length
  a_r3_mosi_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i >= LW'(1) && len_i <= LW'(W)) |=> mosi_o == $past(word_i[len_i - 1'b1]));
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int unsigned IW = 4,
  parameter int unsigned LW = Q_LEN_W,
  parameter int unsigned DW = Q_DLY_W,
  parameter int unsigned PW = Q_PCS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [IW-1:0] start_i,
  input  logic [IW-1:0] end_i,
  input  logic [LW-1:0] len_reg_i,
  input  logic [DW-1:0] post_i,
  input  logic [DW-1:0] lead_i,
  input  logic [DW-1:0] div_i,
  input  logic [PW-1:0] idle_i,
  input  qcmd_t         cmd_i,
  output logic [IW-1:0] nidx_o,
  output logic [IW-1:0] idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic [LW-1:0] len_o,
  output logic          shift_o,
  output logic          sample_o,
  output logic          rx_we_o,
  output logic          sck_o,
  output logic [PW-1:0] pcs_o
);
  seq_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] cnt_q, half, lead_eff, trail;
  logic [LW-1:0] bit_q;
  logic          sck_q;
  logic [PW-1:0] pcs_q;
  qcmd_t         cmd_q;
  logic          cnt_zero, at_end, last;

  assign half     = (div_i == '0) ? DW'(1) : div_i;
  assign lead_eff = cmd_i.use_lead ? ((lead_i == '0) ? DW'(1) : lead_i) : half;
  assign trail    = cmd_q.use_post ? ((post_i == '0) ? DW'(1) : post_i) : DW'(FIXED_TRAIL);
  assign len_o    = cmd_i.use_len
                  ? ((len_reg_i >= LW'(MIN_LEN) && len_reg_i <= LW'(Q_DATA_W)) ? len_reg_i : LW'(Q_DATA_W))
                  : LW'(MIN_LEN);

  assign cnt_zero = (cnt_q == '0);
  assign at_end   = (idx_q == end_i);
  assign last     = (bit_q == LW'(1));
  assign nidx_o   = (state_q == S_IDLE) ? start_i : idx_q + 1'b1;

  assign load_o   = (state_q == S_IDLE && go_i) || (state_q == S_TRAIL && cnt_zero && !at_end);
  assign sample_o = (state_q == S_LEAD || state_q == S_LOW) && cnt_zero;
  assign shift_o  = (state_q == S_HIGH) && cnt_zero && !last;
  assign rx_we_o  = (state_q == S_HIGH) && cnt_zero && last;
  assign done_o   = (state_q == S_TRAIL) && cnt_zero && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      pcs_q   <= '1;
      cmd_q   <= '0;
    end else if (load_o) begin
      idx_q   <= nidx_o;
      pcs_q   <= cmd_i.pcs;
      cmd_q   <= cmd_i;
      bit_q   <= len_o;
      cnt_q   <= lead_eff - 1'b1;
      state_q <= S_LEAD;
    end else begin
      unique case (state_q)
        S_LEAD, S_LOW: begin
          if (cnt_zero) begin
            sck_q   <= 1'b1;
            cnt_q   <= half - 1'b1;
            state_q <= S_HIGH;
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_HIGH: begin
          if (cnt_zero) begin
            sck_q <= 1'b0;
            if (last) begin
              if (!cmd_q.hold) pcs_q <= idle_i;
              cnt_q   <= trail - 1'b1;
              state_q <= S_TRAIL;
            end else begin
              bit_q   <= bit_q - 1'b1;
              cnt_q   <= half - 1'b1;
              state_q <= S_LOW;
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_TRAIL: begin
          if (cnt_zero) state_q <= S_IDLE;  // load_o covers the non-final case
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = (state_q != S_IDLE);
  assign sck_o  = sck_q;
  assign pcs_o  = busy_o ? pcs_q : idle_i;

  // R4: bit counter stays inside the legal length range while shifting
  a_r4_bits_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != S_TRAIL) |-> (bit_q >= LW'(1) && bit_q <= LW'(Q_DATA_W)));
  // R6: no clock edge before the lead delay expires
  a_r6_lead_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LEAD) |-> !sck_q);
  // R1: clock is parked low whenever idle
  a_r1_idle_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_o);
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int unsigned DEPTH  = Q_DEPTH,
  parameter int unsigned DATA_W = Q_DATA_W,
  parameter int unsigned CMD_W  = Q_CMD_W,
  parameter int unsigned ADDR_W = Q_ADDR_W,
  parameter int unsigned LEN_W  = Q_LEN_W,
  parameter int unsigned DLY_W  = Q_DLY_W,
  parameter int unsigned PCS_W  = Q_PCS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [PCS_W-1:0]  pcs_o
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [2:0]       area;
  logic [3:0]       sel;
  logic [IW-1:0]    qaddr;
  logic [IW-1:0]    start_q, end_q;
  logic [LEN_W-1:0] len_q;
  logic [DLY_W-1:0] post_q, lead_q, div_q;
  logic [PCS_W-1:0] idle_q;
  logic             en_q, fin_q;

  logic             reg_wr, ctrl_wr, go, use_seq;
  logic [IW-1:0]    nidx, idx, qraddr;
  logic             busy, done, load, shift_en, sample_en, rx_we;
  logic [LEN_W-1:0] len_cur;
  logic [DATA_W-1:0] tx_rd, rx_rd, rx_word;
  logic [CMD_W-1:0] cmd_rd;

  assign area    = addr_i[ADDR_W-1:4];
  assign sel     = addr_i[3:0];
  assign qaddr   = addr_i[IW-1:0];
  assign reg_wr  = wr_i && (area == AREA_REG);
  assign ctrl_wr = reg_wr && (sel == REG_CTRL);
  assign go      = ctrl_wr && wdata_i[0] && !en_q;
  assign use_seq = en_q || go;
  assign qraddr  = use_seq ? nidx : qaddr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0; end_q <= '0; len_q <= '0;
      post_q  <= '0; lead_q <= '0; div_q <= '0;
      idle_q  <= '1; en_q <= 1'b0; fin_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        unique case (sel)
          REG_PTR:  begin start_q <= wdata_i[IW-1:0]; end_q <= wdata_i[2*IW-1:IW]; end
          REG_LEN:  len_q  <= wdata_i[LEN_W-1:0];
          REG_POST: post_q <= wdata_i[DLY_W-1:0];
          REG_LEAD: lead_q <= wdata_i[DLY_W-1:0];
          REG_DIV:  div_q  <= wdata_i[DLY_W-1:0];
          REG_IDLE: idle_q <= wdata_i[PCS_W-1:0];
          default: ;
        endcase
      end
      if (go)        en_q <= 1'b1;
      else if (done) en_q <= 1'b0;
      if (done)                       fin_q <= 1'b1;
      else if (ctrl_wr && !wdata_i[1]) fin_q <= 1'b0;
    end
  end

  qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .we_i(wr_i && area == AREA_TX), .lock_i(en_q),
    .waddr_i(qaddr), .wdata_i(wdata_i),
    .raddr_i(qraddr), .rdata_o(tx_rd)
  );

  qspi_ram #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdq (
    .clk_i, .rst_ni,
    .we_i(wr_i && area == AREA_CMD), .lock_i(en_q),
    .waddr_i(qaddr), .wdata_i(wdata_i[CMD_W-1:0]),
    .raddr_i(qraddr), .rdata_o(cmd_rd)
  );

  qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .we_i(rx_we), .lock_i(1'b0),
    .waddr_i(idx), .wdata_i(rx_word),
    .raddr_i(qaddr), .rdata_o(rx_rd)
  );

  qspi_seq #(.IW(IW), .LW(LEN_W), .DW(DLY_W), .PW(PCS_W)) u_seq (
    .clk_i, .rst_ni,
    .go_i(go), .start_i(start_q), .end_i(end_q),
    .len_reg_i(len_q), .post_i(post_q), .lead_i(lead_q), .div_i(div_q),
    .idle_i(idle_q), .cmd_i(qcmd_t'(cmd_rd)),
    .nidx_o(nidx), .idx_o(idx), .busy_o(busy), .done_o(done),
    .load_o(load), .len_o(len_cur), .shift_o(shift_en), .sample_o(sample_en),
    .rx_we_o(rx_we), .sck_o(sck_o), .pcs_o(pcs_o)
  );

  qspi_shift #(.W(DATA_W), .LW(LEN_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i(load), .len_i(len_cur), .word_i(tx_rd),
    .shift_i(shift_en), .sample_i(sample_en), .miso_i(miso_i),
    .mosi_o(mosi_o), .rx_o(rx_word)
  );

  always_comb begin
    rdata_o = '0;
    unique case (area)
      AREA_TX:  rdata_o = tx_rd;
      AREA_CMD: rdata_o = DATA_W'(cmd_rd);
      AREA_RX:  rdata_o = rx_rd;
      AREA_REG: begin
        unique case (sel)
          REG_PTR:  rdata_o = DATA_W'({end_q, start_q});
          REG_LEN:  rdata_o = DATA_W'(len_q);
          REG_POST: rdata_o = DATA_W'(post_q);
          REG_LEAD: rdata_o = DATA_W'(lead_q);
          REG_DIV:  rdata_o = DATA_W'(div_q);
          REG_IDLE: rdata_o = DATA_W'(idle_q);
          REG_CTRL: rdata_o = DATA_W'({fin_q, en_q});
          default:  rdata_o = '0;
        endcase
      end
      default: rdata_o = '0;
    endcase
  end

  // R10: the finished flag never rises while the enable bit is still set
  a_r10_fin_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fin_q) |-> !en_q);
  // R10: enable and sequencer activity agree after the start edge
  a_r10_busy_tracks_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> en_q);
endmodule

// File: tb/tb_qspi_master.sv
module tb_qspi_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sck, mosi, miso;
  logic [3:0]  pcs;

  always #5 clk = ~clk;
  assign miso = ~mosi;  // loopback: received word is the inverse of the sent one

  qspi_master dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .pcs_o(pcs)
  );

  int n_chk = 0, n_bad = 0;
  bit fin_flag = 0;
  logic [3:0] idle_exp = 4'hF;

  int mon_n, lead_s, hi_s, lo_s, gap_s, hold_s, gap_ref;
  logic [31:0] mon_bits;
  logic [3:0]  mon_pcs;
  logic        prev_sck = 1'b0;
  bit          run_active = 0;

  always @(negedge clk) begin
    if (sck && !prev_sck) begin
      mon_n++;
      mon_bits = {mon_bits[30:0], mosi};
      mon_pcs = pcs;
    end
    prev_sck = sck;
    if (run_active) begin
      if (mon_n == 0 && !sck && pcs != idle_exp) lead_s++;
      if (mon_n == 1 && sck) hi_s++;
      if (mon_n == 1 && !sck && pcs != idle_exp) lo_s++;
      if (mon_n == gap_ref && !sck && pcs == idle_exp) gap_s++;
      if (mon_n == gap_ref && !sck && pcs != idle_exp) hold_s++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run(input logic [3:0] s, input logic [3:0] e, input int gref);
    logic [15:0] st;
    wr_reg(7'h30, {8'h00, e, s});
    mon_n = 0; lead_s = 0; hi_s = 0; lo_s = 0; gap_s = 0; hold_s = 0;
    mon_bits = '0; mon_pcs = '0; gap_ref = gref;
    run_active = 1;
    wr_reg(7'h36, 16'h0001);
    st = '0;
    while (!st[1]) rd_reg(7'h36, st);
    run_active = 0;
    chk("R10 ctrl after completion", st, 16'h0002);
    wr_reg(7'h36, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin_flag) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, tx, mask;
    int n, lv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 pcs", pcs, 4'hF);
    chk("R1 sck", sck, 1'b0);
    chk("R1 mosi", mosi, 1'b0);
    rd_reg(7'h36, d); chk("R1 ctrl", d, 16'h0);
    rd_reg(7'h20, d); chk("R1 rx0", d, 16'h0);

    // R2 idle level register drives PCS, readback
    wr_reg(7'h35, 16'h0005);
    chk("R2 idle pcs", pcs, 4'h5);
    wr_reg(7'h35, 16'h000F);
    chk("R2 idle pcs restore", pcs, 4'hF);
    wr_reg(7'h33, 16'h00A7);
    rd_reg(7'h33, d); chk("R2 lead readback", d, 16'h00A7);

    // R3 R4 R8 length sweep on entry 3
    wr_reg(7'h34, 16'h0001);
    for (int k = 0; k < 13; k++) begin
      logic bitse;
      bitse = (k != 12);
      lv = (k < 9) ? k + 8 : (k == 9) ? 0 : (k == 10) ? 5 : 12;
      if (k == 11) lv = 20;
      n = !bitse ? 8 : (lv >= 8 && lv <= 16) ? lv : 16;
      tx = 16'hC3A5 ^ (16'(lv) * 16'h0111);
      mask = (n == 16) ? 16'hFFFF : 16'((32'h1 << n) - 1);
      wr_reg(7'h31, 16'(lv));
      wr_reg(7'h03, tx);
      wr_reg(7'h13, bitse ? 16'h004A : 16'h000A);
      run(4'd3, 4'd3, 99);
      chk("R4 bit count", mon_n, n);
      chk("R3 mosi bits", mon_bits[15:0] & mask, tx & mask);
      rd_reg(7'h23, d); chk("R3 rx word", d, ~tx & mask);
      chk("R8 pcs during word", mon_pcs, 4'hA);
    end

    // R5 R6 R7 timing sweep over entries 0,1 with hold clear
    for (int dv = 1; dv <= 3; dv++) begin
      for (int m = 0; m < 4; m++) begin
        int ld, pd, h, l, t;
        ld = (dv == 2) ? 0 : 5;
        pd = (dv == 3) ? 0 : 4;
        h = dv;
        l = m[0] ? ((ld == 0) ? 1 : ld) : h;
        t = m[1] ? ((pd == 0) ? 1 : pd) : 17;
        wr_reg(7'h34, 16'(dv));
        wr_reg(7'h33, 16'(ld));
        wr_reg(7'h32, 16'(pd));
        wr_reg(7'h00, 16'h00A5);
        wr_reg(7'h01, 16'h003C);
        wr_reg(7'h10, {8'h00, 2'b00, m[1], m[0], 4'hC});
        wr_reg(7'h11, {8'h00, 2'b00, m[1], m[0], 4'hC});
        run(4'd0, 4'd1, 8);
        chk("R6 lead cycles", lead_s, l);
        chk("R5 high phase", hi_s, h);
        chk("R5 low phase", lo_s, h);
        chk("R7 trail cycles", gap_s, t);
      end
    end

    // R8 hold bit keeps the pattern between entries
    wr_reg(7'h34, 16'h0001);
    wr_reg(7'h10, 16'h0086);
    wr_reg(7'h11, 16'h0006);
    run(4'd0, 4'd1, 8);
    chk("R8 no idle gap with hold", gap_s, 0);
    chk("R8 held low cycles", hold_s, 18);
    chk("R8 pattern", mon_pcs, 4'h6);
    chk("R8 idle after completion", pcs, 4'hF);

    // R9 range wraps 14,15,0,1
    for (int i = 0; i < 4; i++) begin
      int q;
      q = (14 + i) % 16;
      wr_reg(7'(q), 16'h1100 + 16'(q));
      wr_reg(7'(16 + q), 16'h0009);
    end
    run(4'd14, 4'd1, 99);
    chk("R9 total bits", mon_n, 32);
    for (int i = 0; i < 4; i++) begin
      int q;
      q = (14 + i) % 16;
      rd_reg(7'(32 + q), d);
      chk("R9 rx in range", d, ~(16'h1100 + 16'(q)) & 16'h00FF);
    end
    rd_reg(7'h22, d); chk("R9 rx outside range", d, 16'h0);

    // R10 R11 queue lock during a long run
    wr_reg(7'h05, 16'h1234);
    wr_reg(7'h15, 16'h005A);
    wr_reg(7'h34, 16'd20);
    wr_reg(7'h31, 16'd16);
    wr_reg(7'h17, 16'h0043);
    wr_reg(7'h30, 16'h0077);
    wr_reg(7'h36, 16'h0001);
    wr_reg(7'h05, 16'hBEEF);
    wr_reg(7'h15, 16'h00FF);
    rd_reg(7'h36, d); chk("R10 enable while running", d, 16'h0001);
    d = '0;
    while (!d[1]) rd_reg(7'h36, d);
    chk("R10 enable cleared", d, 16'h0002);
    rd_reg(7'h05, d); chk("R11 tx locked", d, 16'h1234);
    rd_reg(7'h15, d); chk("R11 cmd locked", d, 16'h005A);
    wr_reg(7'h36, 16'h0000);
    rd_reg(7'h36, d); chk("R10 finished cleared", d, 16'h0000);
    wr_reg(7'h05, 16'hBEEF);
    rd_reg(7'h05, d); chk("R11 tx writable when idle", d, 16'hBEEF);

    fin_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule